// File: doc/BRIEF.md
# ASID-Tagged Fully Associative Translation Cache

This block caches virtual-to-physical page translations. Each slot holds a page mapping tagged with an 8-bit address-space identifier, so mappings from several processes can be held at once. A lookup compares the page-number part of the virtual address and the requesting identifier against every slot at the same time, in the same cycle. On a hit it returns the physical address: the stored frame number placed above the untranslated 12-bit page offset.

After a miss, the surrounding logic walks the page table and writes the result through the fill port. A fill reuses a slot that already holds the same page and identifier. Failing that, it takes the lowest-numbered empty slot. When every slot is full, it evicts a victim chosen either by true least-recently-used order or by a pseudo-random generator, depending on a mode input. Any translation can be written as pinned. Pinned slots are never evicted, and they survive the flush command, which empties every other slot.

Top module: `asid_tlb`

## Requirements
- R1: After reset every slot is empty, and every lookup misses.
- R2: On a hit, `lk_paddr` equals the stored 20-bit frame number in bits 31..12 and `lk_vaddr[11:0]` in bits 11..0. On a miss, `lk_paddr` is zero. Hit, address and slot are combinational in the cycle the lookup is presented.
- R3: A hit needs a valid slot whose page number and identifier both equal the request. The same page under another identifier misses.
- R4: A fill that matches no existing slot goes to the lowest-numbered empty slot, reported as `lk_slot` on later hits.
- R5: A fill whose page number and identifier match a valid slot overwrites that slot in place: the frame and pin flag are replaced and no second copy is made. At most one slot hits any lookup.
- R6: Asserting `flush` for one cycle empties every unpinned slot, and pinned slots keep hitting.
- R7: With `policy_rand`=0 and all slots full, a fill evicts the least recently used unpinned slot. A hit or a fill marks its slot most recent, and when a fill and a hit fall in the same cycle only the filled slot is marked. With four slots, a cyclic sweep over five pages misses on every access.
- R8: A pinned slot is never chosen for eviction in either policy.
- R9: With `policy_rand`=1 and all slots full, the victim is an unpinned slot picked from a free-running 16-bit LFSR, so a cyclic sweep slightly larger than the cache still produces hits.
- R10: When `flush` and `fill_valid` are high in the same cycle, the flush takes effect and the fill is dropped.
- R11: When every slot is valid and pinned, a fill for a new page is dropped and all existing translations are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| policy_rand | input | 1 | Victim policy: 0 least recently used, 1 pseudo-random |
| flush | input | 1 | Empty all unpinned slots this cycle |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Address-space identifier of the request |
| lk_hit | output | 1 | Lookup hit |
| lk_paddr | output | 32 | Translated physical address, zero on miss |
| lk_slot | output | 2 | Index of the hitting slot |
| fill_valid | input | 1 | Write a translation |
| fill_vpn | input | 20 | Virtual page number to write |
| fill_asid | input | 8 | Identifier to write |
| fill_pfn | input | 20 | Physical frame number to write |
| fill_pin | input | 1 | Mark the written slot as pinned |

## Verification
The checker watches four things on every cycle:
- a miss gives a zero address, and a hit carries the offset through unchanged;
- no two slots hit at once;
- a flush leaves exactly the pinned slots valid;
- a valid pinned slot never loses its valid bit.

Other properties depend on a history of accesses, so only the bench scenarios can show them. These include which slot a fill lands in, the order of least-recently-used eviction, the miss on every access of the five-page sweep, and the hits that random replacement still finds on that sweep.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;

    localparam int VA_W   = 32;
    localparam int PA_W   = 32;
    localparam int OFF_W  = 12;
    localparam int ASID_W = 8;
    localparam int VPN_W  = VA_W - OFF_W;
    localparam int PFN_W  = PA_W - OFF_W;

    typedef logic [VPN_W-1:0]  vpn_t;
    typedef logic [PFN_W-1:0]  pfn_t;
    typedef logic [ASID_W-1:0] asid_t;

    typedef struct packed {
        logic  valid;
        logic  pinned;
        asid_t asid;
        vpn_t  vpn;
        pfn_t  pfn;
    } tlb_slot_t;

    typedef enum logic {
        VICTIM_LRU  = 1'b0,
        VICTIM_RAND = 1'b1
    } victim_mode_e;

    function automatic logic [PA_W-1:0] join_paddr(input pfn_t pfn,
                                                   input logic [VA_W-1:0] va);
        return {pfn, va[OFF_W-1:0]};
    endfunction

endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import asid_tlb_pkg::*;
#(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  tlb_slot_t        slots [N],
    input  vpn_t             req_vpn,
    input  asid_t            req_asid,
    output logic [N-1:0]     hit_vec,
    output logic             hit,
    output logic [IW-1:0]    hit_idx
);

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = slots[g].valid &&
                            (slots[g].vpn == req_vpn) &&
                            (slots[g].asid == req_asid);
    end

    assign hit = |hit_vec;

    always_comb begin
        hit_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx = IW'(i);
        end
    end

endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          touch_en,
    input  logic [IW-1:0] touch_idx,
    input  logic [N-1:0]  cand,
    output logic [IW-1:0] victim_idx,
    output logic          victim_ok
);

    logic [IW-1:0] age_q [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) age_q[i] <= IW'(i);
        end else if (touch_en) begin
            for (int i = 0; i < N; i++) begin
                if (IW'(i) == touch_idx)
                    age_q[i] <= '0;
                else if (age_q[i] < age_q[touch_idx])
                    age_q[i] <= age_q[i] + 1'b1;
            end
        end
    end

    always_comb begin
        victim_idx = '0;
        victim_ok  = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!victim_ok || age_q[i] > age_q[victim_idx])) begin
                victim_idx = IW'(i);
                victim_ok  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/tlb_rand_pick.sv
module tlb_rand_pick #(
    parameter int          N    = 4,
    parameter int          IW   = 2,
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  cand,
    output logic [IW-1:0] victim_idx,
    output logic          victim_ok
);

    logic [15:0] lfsr_q;
    logic        fb;
    int          start;

    assign fb = lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10];

    always_ff @(posedge clk) begin
        if (rst) lfsr_q <= SEED;
        else     lfsr_q <= {lfsr_q[14:0], fb};
    end

    assign start = int'(lfsr_q[7:0]) % N;

    always_comb begin
        victim_idx = '0;
        victim_ok  = 1'b0;
        for (int k = N - 1; k >= 0; k--) begin
            if (cand[(start + k) % N]) begin
                victim_idx = IW'((start + k) % N);
                victim_ok  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
    import asid_tlb_pkg::*;
#(
    parameter int ENTRIES = 4,
    localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              policy_rand,
    input  logic              flush,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_hit,
    output logic [PA_W-1:0]   lk_paddr,
    output logic [IW-1:0]     lk_slot,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic              fill_pin
);

    tlb_slot_t          slots_q [ENTRIES];
    logic [ENTRIES-1:0] ent_valid;
    logic [ENTRIES-1:0] ent_pinned;
    logic [ENTRIES-1:0] lk_hit_vec;
    logic [ENTRIES-1:0] fl_hit_vec;
    logic               lk_any;
    logic               fl_any;
    logic [IW-1:0]      lk_idx;
    logic [IW-1:0]      fl_idx;
    logic [IW-1:0]      free_idx;
    logic               free_any;
    logic [IW-1:0]      lru_idx;
    logic               lru_ok;
    logic [IW-1:0]      rnd_idx;
    logic               rnd_ok;
    logic [IW-1:0]      fill_slot;
    logic               fill_ok;
    logic               touch_en;
    logic [IW-1:0]      touch_idx;
    victim_mode_e       mode;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_flags
        assign ent_valid[g]  = slots_q[g].valid;
        assign ent_pinned[g] = slots_q[g].pinned;
    end

    tlb_match #(.N(ENTRIES), .IW(IW)) lk_match_i (
        .slots    (slots_q),
        .req_vpn  (lk_vaddr[VA_W-1:OFF_W]),
        .req_asid (lk_asid),
        .hit_vec  (lk_hit_vec),
        .hit      (lk_any),
        .hit_idx  (lk_idx)
    );

    tlb_match #(.N(ENTRIES), .IW(IW)) fl_match_i (
        .slots    (slots_q),
        .req_vpn  (fill_vpn),
        .req_asid (fill_asid),
        .hit_vec  (fl_hit_vec),
        .hit      (fl_any),
        .hit_idx  (fl_idx)
    );

    tlb_lru #(.N(ENTRIES), .IW(IW)) lru_i (
        .clk        (clk),
        .rst        (rst),
        .touch_en   (touch_en),
        .touch_idx  (touch_idx),
        .cand       (~ent_pinned),
        .victim_idx (lru_idx),
        .victim_ok  (lru_ok)
    );

    tlb_rand_pick #(.N(ENTRIES), .IW(IW)) rnd_i (
        .clk        (clk),
        .rst        (rst),
        .cand       (~ent_pinned),
        .victim_idx (rnd_idx),
        .victim_ok  (rnd_ok)
    );

    // lookup result
    assign lk_hit   = lk_valid && lk_any;
    assign lk_slot  = lk_idx;
    assign lk_paddr = lk_hit ? join_paddr(slots_q[lk_idx].pfn, lk_vaddr) : '0;

    // lowest-numbered empty slot
    always_comb begin
        free_idx = '0;
        free_any = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!ent_valid[i]) begin
                free_idx = IW'(i);
                free_any = 1'b1;
            end
        end
    end

    assign mode = victim_mode_e'(policy_rand);

    // slot selection: in-place match, then empty slot, then policy victim
    always_comb begin
        fill_slot = '0;
        fill_ok   = 1'b0;
        if (fill_valid && !flush) begin
            if (fl_any) begin
                fill_slot = fl_idx;
                fill_ok   = 1'b1;
            end else if (free_any) begin
                fill_slot = free_idx;
                fill_ok   = 1'b1;
            end else if (mode == VICTIM_RAND) begin
                fill_slot = rnd_idx;
                fill_ok   = rnd_ok;
            end else begin
                fill_slot = lru_idx;
                fill_ok   = lru_ok;
            end
        end
    end

    // recency update: a fill outranks a simultaneous hit
    always_comb begin
        touch_en  = fill_ok || lk_hit;
        touch_idx = fill_ok ? fill_slot : lk_idx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) slots_q[i] <= '0;
        end else if (flush) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (!slots_q[i].pinned) slots_q[i].valid <= 1'b0;
            end
        end else if (fill_ok) begin
            slots_q[fill_slot] <= '{valid:  1'b1,
                                    pinned: fill_pin,
                                    asid:   fill_asid,
                                    vpn:    fill_vpn,
                                    pfn:    fill_pfn};
        end
    end

endmodule

// File: rtl/asid_tlb_sva.sv
module asid_tlb_sva
    import asid_tlb_pkg::*;
#(
    parameter int ENTRIES = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               flush,
    input logic               lk_hit,
    input logic [VA_W-1:0]    lk_vaddr,
    input logic [PA_W-1:0]    lk_paddr,
    input logic [ENTRIES-1:0] ent_valid,
    input logic [ENTRIES-1:0] ent_pinned,
    input logic [ENTRIES-1:0] lk_hit_vec
);

    p_reset_empty_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> ent_valid == '0);

    p_miss_zero_r2: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> lk_paddr == '0);

    p_offset_pass_r2: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]);

    p_single_hit_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_hit_vec));

    p_flush_pins_only_r6: assert property (@(posedge clk) disable iff (rst)
        flush |=> ent_valid == $past(ent_valid & ent_pinned));

    p_pinned_stay_r8: assert property (@(posedge clk) disable iff (rst)
        !$fell(rst) |-> (($past(ent_valid & ent_pinned) & ~ent_valid) == '0));

endmodule

bind asid_tlb asid_tlb_sva #(.ENTRIES(ENTRIES)) sva_i (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush),
    .lk_hit     (lk_hit),
    .lk_vaddr   (lk_vaddr),
    .lk_paddr   (lk_paddr),
    .ent_valid  (ent_valid),
    .ent_pinned (ent_pinned),
    .lk_hit_vec (lk_hit_vec)
);

// File: tb/asid_tlb_tb_top.sv
module asid_tlb_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        policy_rand = 1'b0;
    logic        flush = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [7:0]  lk_asid = '0;
    logic        lk_hit;
    logic [31:0] lk_paddr;
    logic [1:0]  lk_slot;
    logic        fill_valid = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [7:0]  fill_asid = '0;
    logic [19:0] fill_pfn = '0;
    logic        fill_pin = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    asid_tlb #(.ENTRIES(4)) dut_i (
        .clk(clk), .rst(rst), .policy_rand(policy_rand), .flush(flush),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid),
        .lk_hit(lk_hit), .lk_paddr(lk_paddr), .lk_slot(lk_slot),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
        .fill_pfn(fill_pfn), .fill_pin(fill_pin)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic look(input logic [19:0] vpn, input logic [11:0] off, input logic [7:0] asid,
                        output logic h, output logic [31:0] pa, output logic [1:0] sl);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_vaddr = {vpn, off};
        lk_asid  = asid;
        #1;
        h  = lk_hit;
        pa = lk_paddr;
        sl = lk_slot;
        @(posedge clk);
        #1 lk_valid = 1'b0;
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [7:0] asid,
                        input logic [19:0] pfn, input logic pin);
        @(negedge clk);
        fill_valid = 1'b1;
        fill_vpn   = vpn;
        fill_asid  = asid;
        fill_pfn   = pfn;
        fill_pin   = pin;
        @(posedge clk);
        #1 fill_valid = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(posedge clk);
        #1 flush = 1'b0;
    endtask

    // lookup, and fill on a miss; returns hit
    task automatic access(input logic [19:0] vpn, output logic h);
        logic [31:0] pa;
        logic [1:0]  sl;
        look(vpn, 12'h010, 8'd1, h, pa, sl);
        if (!h) fill(vpn, 8'd1, vpn + 20'h100, 1'b0);
    endtask

    task automatic t_reset_state();
        logic h; logic [31:0] pa; logic [1:0] sl;
        look(20'h3, 12'h004, 8'd1, h, pa, sl);
        check("R1 miss after reset", {31'd0, h}, 32'd0);
        check("R2 zero address on miss", pa, 32'd0);
    endtask

    task automatic t_basic_fill();
        logic h; logic [31:0] pa; logic [1:0] sl;
        fill(20'h3, 8'd1, 20'h7, 1'b0);
        look(20'h3, 12'h004, 8'd1, h, pa, sl);
        check("R2 hit", {31'd0, h}, 32'd1);
        check("R2 paddr 0x3004->0x7004", pa, 32'h7004);
        check("R4 first fill slot 0", {30'd0, sl}, 32'd0);
        fill(20'h2, 8'd1, 20'h4, 1'b0);
        look(20'h2, 12'habc, 8'd1, h, pa, sl);
        check("R2 paddr offset pass", pa, 32'h4abc);
        check("R4 second fill slot 1", {30'd0, sl}, 32'd1);
    endtask

    task automatic t_asid();
        logic h; logic [31:0] pa; logic [1:0] sl;
        look(20'h3, 12'h004, 8'd2, h, pa, sl);
        check("R3 other asid misses", {31'd0, h}, 32'd0);
        fill(20'h3, 8'd2, 20'h9, 1'b0);
        look(20'h3, 12'h004, 8'd2, h, pa, sl);
        check("R3 asid 2 paddr", pa, 32'h9004);
        check("R4 asid 2 slot 2", {30'd0, sl}, 32'd2);
        look(20'h3, 12'h004, 8'd1, h, pa, sl);
        check("R3 asid 1 kept", pa, 32'h7004);
    endtask

    task automatic t_overwrite();
        logic h; logic [31:0] pa; logic [1:0] sl;
        fill(20'h3, 8'd1, 20'h55, 1'b0);
        look(20'h3, 12'h004, 8'd1, h, pa, sl);
        check("R5 overwrite new pfn", pa, 32'h55004);
        check("R5 overwrite same slot", {30'd0, sl}, 32'd0);
        fill(20'h10, 8'd1, 20'h11, 1'b0);
        look(20'h10, 12'h000, 8'd1, h, pa, sl);
        check("R5 slot 3 still free", {30'd0, sl}, 32'd3);
    endtask

    task automatic t_flush_pin();
        logic h; logic [31:0] pa; logic [1:0] sl;
        do_flush();
        look(20'h2, 12'h000, 8'd1, h, pa, sl);
        check("R6 flush empties", {31'd0, h}, 32'd0);
        fill(20'h40, 8'd1, 20'h80, 1'b1);
        fill(20'h1, 8'd1, 20'h81, 1'b0);
        do_flush();
        look(20'h40, 12'h008, 8'd1, h, pa, sl);
        check("R6 pinned survives flush", pa, 32'h80008);
        check("R6 pinned slot 0", {30'd0, sl}, 32'd0);
        look(20'h1, 12'h000, 8'd1, h, pa, sl);
        check("R6 unpinned cleared", {31'd0, h}, 32'd0);
        fill(20'h2, 8'd1, 20'h82, 1'b0);
        look(20'h2, 12'h000, 8'd1, h, pa, sl);
        check("R4 refill after flush slot 1", {30'd0, sl}, 32'd1);
    endtask

    task automatic t_lru_order();
        logic h; logic [31:0] pa; logic [1:0] sl;
        do_reset();
        policy_rand = 1'b0;
        for (int i = 0; i < 4; i++) fill(20'(8'hA0 + i), 8'd1, 20'(8'hB0 + i), 1'b0);
        look(20'hA0, 12'h0, 8'd1, h, pa, sl);
        fill(20'hAF, 8'd1, 20'hBF, 1'b0);
        look(20'hAF, 12'h0, 8'd1, h, pa, sl);
        check("R7 victim is LRU slot 1", {30'd0, sl}, 32'd1);
        look(20'hA1, 12'h0, 8'd1, h, pa, sl);
        check("R7 LRU page evicted", {31'd0, h}, 32'd0);
        look(20'hA0, 12'h0, 8'd1, h, pa, sl);
        check("R7 recently hit page kept", {31'd0, h}, 32'd1);
    endtask

    task automatic t_lru_thrash();
        logic h;
        int misses = 0;
        do_reset();
        policy_rand = 1'b0;
        for (int r = 0; r < 3; r++)
            for (int p = 0; p < 5; p++) begin
                access(20'(p), h);
                if (!h) misses++;
            end
        check("R7 cyclic 5 pages all miss", 32'(misses), 32'd15);
    endtask

    task automatic t_lru_pin();
        logic h; logic [31:0] pa; logic [1:0] sl;
        do_reset();
        policy_rand = 1'b0;
        fill(20'h50, 8'd1, 20'h60, 1'b1);
        fill(20'h51, 8'd1, 20'h61, 1'b0);
        fill(20'h52, 8'd1, 20'h62, 1'b0);
        fill(20'h53, 8'd1, 20'h63, 1'b0);
        look(20'h51, 12'h0, 8'd1, h, pa, sl);
        look(20'h52, 12'h0, 8'd1, h, pa, sl);
        look(20'h53, 12'h0, 8'd1, h, pa, sl);
        fill(20'h54, 8'd1, 20'h64, 1'b0);
        look(20'h50, 12'h0, 8'd1, h, pa, sl);
        check("R8 pinned LRU slot kept", pa, 32'h60000);
        look(20'h54, 12'h0, 8'd1, h, pa, sl);
        check("R8 oldest unpinned slot 1 taken", {30'd0, sl}, 32'd1);
    endtask

    task automatic t_random();
        logic h; logic [31:0] pa; logic [1:0] sl;
        int hits = 0;
        do_reset();
        policy_rand = 1'b1;
        fill(20'h90, 8'd1, 20'h99, 1'b1);
        for (int r = 0; r < 10; r++)
            for (int p = 1; p < 5; p++) begin
                access(20'(p), h);
                if (h) hits++;
            end
        check("R9 random sweep finds hits", {31'd0, hits > 0}, 32'd1);
        look(20'h90, 12'h0, 8'd1, h, pa, sl);
        check("R8 pinned kept under random", pa, 32'h99000);
        policy_rand = 1'b0;
    endtask

    task automatic t_flush_fill();
        logic h; logic [31:0] pa; logic [1:0] sl;
        do_reset();
        @(negedge clk);
        flush      = 1'b1;
        fill_valid = 1'b1;
        fill_vpn   = 20'h77;
        fill_asid  = 8'd1;
        fill_pfn   = 20'h78;
        fill_pin   = 1'b0;
        @(posedge clk);
        #1;
        flush      = 1'b0;
        fill_valid = 1'b0;
        look(20'h77, 12'h0, 8'd1, h, pa, sl);
        check("R10 fill dropped under flush", {31'd0, h}, 32'd0);
    endtask

    task automatic t_all_pinned();
        logic h; logic [31:0] pa; logic [1:0] sl;
        do_reset();
        for (int i = 0; i < 4; i++) fill(20'(8'h20 + i), 8'd1, 20'(8'h30 + i), 1'b1);
        fill(20'h2F, 8'd1, 20'h3F, 1'b0);
        look(20'h2F, 12'h0, 8'd1, h, pa, sl);
        check("R11 fill dropped when all pinned", {31'd0, h}, 32'd0);
        for (int i = 0; i < 4; i++) begin
            look(20'(8'h20 + i), 12'h0, 8'd1, h, pa, sl);
            check("R11 pinned entry kept", pa, {12'd0, 8'h30 + 8'(i), 12'h000});
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R1 watchdog: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_basic_fill();
        t_asid();
        t_overwrite();
        t_flush_pin();
        t_lru_order();
        t_lru_thrash();
        t_lru_pin();
        t_random();
        t_flush_fill();
        t_all_pinned();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule